// File: doc/BRIEF.md
# Time Slot Clock Gate for a Serial Data Link Channel

This block sits between a serial line and one data link channel and decides on which bit clocks the channel may shift. In pass-through mode the line's receive and transmit clocks reach the channel unchanged and the channel is always enabled. In multiplexed mode the transmit clock pin is read as a frame-synchronization input instead. Both channel clocks then come from the receive bit clock. A bit counter tracks the position inside a TDM frame. The channel enable is raised only for a chosen number of leading bits of one programmed time slot.

Enabling fewer than all bits of the slot lowers the channel rate in steps of one bit per frame: 8 bits give 64 kbit/s, 7 bits give 56 kbit/s, and 1 bit gives 8 kbit/s. A parallel configuration port loads the slot number, the bit count and the mode into shadow registers. The shadow values become active only at the next frame-sync rising edge, so a frame that is in progress is never disturbed.

Top module: `tsa_clock_gate`

## Requirements
- R1: While reset is held and after it is released, the block is in pass-through mode with slot 0 and 8 bits active, so `chanClkEn` is 1.
- R2: In pass-through mode `chanRxClk` equals `lineClk`, `chanTxClk` equals `txClkOrSync`, and `chanClkEn` is 1.
- R3: In multiplexed mode both `chanRxClk` and `chanTxClk` equal `lineClk`.
- R4: A frame sync is a `lineClk` rising edge at which `txClkOrSync` is sampled 1 after being sampled 0 at the previous edge. The bit time that follows that edge is bit 0. The count rises by one per `lineClk` and wraps to 0 after bit SLOTS*SLOT_BITS-1 (255 by default) if no new sync arrives.
- R5: In multiplexed mode `chanClkEn` is 1 exactly during bits slot*SLOT_BITS through slot*SLOT_BITS+n-1 of the frame, where slot is the active slot number and n is the active bit count.
- R6: Every bit count from 1 to SLOT_BITS opens a window of exactly that many consecutive bits, for every slot from 0 to SLOTS-1.
- R7: A written bit count of 0 or greater than SLOT_BITS is clamped to SLOT_BITS.
- R8: A write (`cfgWrite` 1 at a `lineClk` rising edge) changes only the shadow settings. Mode, slot and bit count change only at the next frame sync, and the running frame keeps its old window until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lineClk | input | 1 | Receive bit clock of the serial line; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| txClkOrSync | input | 1 | Transmit clock in pass-through mode, frame sync in multiplexed mode |
| cfgWrite | input | 1 | Loads the configuration inputs into the shadow registers |
| cfgMuxMode | input | 1 | 1 selects multiplexed mode, 0 selects pass-through |
| cfgSlot | input | 5 | Time slot number, 0 to SLOTS-1 |
| cfgBits | input | 4 | Number of enabled bits of the slot, 1 to SLOT_BITS |
| chanRxClk | output | 1 | Receive clock to the channel |
| chanTxClk | output | 1 | Transmit clock to the channel |
| chanClkEn | output | 1 | Clock enable to the channel |

## Verification
A wrong bit count, or a window that starts at the wrong place, shows on `chanClkEn` within one frame of the sync that starts it. The bench therefore compares every bit time of every frame against a frame model for all slots and all legal bit counts. If a setting is promoted too early, the frame in which the write happens already shows the changed window or clock routing. A missed promotion keeps the old window after the sync. A write in mid-frame followed by a frame that wraps without a sync exposes both faults.

// File: rtl/tsa_clock_gate_pkg.sv
package tsa_clock_gate_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic syncHit;   // frame sync seen at this edge
    logic muxMode;   // active mode: 1 = multiplexed
  } tsaCtrl_t;

endpackage

// File: rtl/tsa_clock_gate_ctrl.sv
module tsa_clock_gate_ctrl
  import tsa_clock_gate_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS + 1)
) (
  input  logic              lineClk,
  input  logic              rst_n,
  input  logic              syncPin,
  input  logic              cfgWrite,
  input  logic              cfgMuxMode,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [BIT_W-1:0]  cfgBits,
  output tsaCtrl_t          strobes,
  output logic [SLOT_W-1:0] actSlot,
  output logic [BIT_W-1:0]  actBits
);

  localparam logic [BIT_W-1:0] FULL_BITS = BIT_W'(SLOT_BITS);

  logic              syncPrev;
  logic              syncHit;
  logic              shMux;
  logic [SLOT_W-1:0] shSlot;
  logic [BIT_W-1:0]  shBits;
  logic [BIT_W-1:0]  bitsClamped;
  logic              actMux;

  assign syncHit = syncPin & ~syncPrev;

  always_comb begin
    if (cfgBits == '0 || cfgBits > FULL_BITS) bitsClamped = FULL_BITS;
    else                                      bitsClamped = cfgBits;
  end

  // Shadow settings: written at any time
  always_ff @(posedge lineClk or negedge rst_n) begin
    if (!rst_n) begin
      shMux  <= 1'b0;
      shSlot <= '0;
      shBits <= FULL_BITS;
    end else if (cfgWrite) begin
      shMux  <= cfgMuxMode;
      shSlot <= cfgSlot;
      shBits <= bitsClamped;
    end
  end

  // Active settings: promoted only on frame sync
  always_ff @(posedge lineClk or negedge rst_n) begin
    if (!rst_n) begin
      syncPrev <= 1'b0;
      actMux   <= 1'b0;
      actSlot  <= '0;
      actBits  <= FULL_BITS;
    end else begin
      syncPrev <= syncPin;
      if (syncHit) begin
        actMux  <= shMux;
        actSlot <= shSlot;
        actBits <= shBits;
      end
    end
  end

  assign strobes.syncHit = syncHit;
  assign strobes.muxMode = actMux;

  // R7: active bit count always within 1..SLOT_BITS
  p_bits_legal_r7: assert property (@(posedge lineClk) disable iff (!rst_n)
    (actBits != '0) && (actBits <= FULL_BITS));

  // R8: active settings move only at a frame sync
  p_cfg_hold_r8: assert property (@(posedge lineClk) disable iff (!rst_n)
    !syncHit |=> $stable({actMux, actSlot, actBits}));

endmodule

// File: rtl/tsa_clock_gate_datapath.sv
module tsa_clock_gate_datapath
  import tsa_clock_gate_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int BIT_W     = $clog2(SLOT_BITS + 1),
  localparam int FRAME_LEN = SLOTS * SLOT_BITS,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int WIN_W     = POS_W + 1
) (
  input  logic              lineClk,
  input  logic              rst_n,
  input  logic              txClkPin,
  input  tsaCtrl_t          strobes,
  input  logic [SLOT_W-1:0] actSlot,
  input  logic [BIT_W-1:0]  actBits,
  output logic              chanRxClk,
  output logic              chanTxClk,
  output logic              chanClkEn
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] bitPos;
  logic [WIN_W-1:0] winStart;
  logic [WIN_W-1:0] winEnd;
  logic [WIN_W-1:0] posWide;
  logic             inWindow;

  // Bit position within the TDM frame
  always_ff @(posedge lineClk or negedge rst_n) begin
    if (!rst_n)                  bitPos <= '0;
    else if (strobes.syncHit)    bitPos <= '0;
    else if (bitPos == LAST_POS) bitPos <= '0;
    else                         bitPos <= bitPos + 1'b1;
  end

  assign posWide  = {1'b0, bitPos};
  assign winStart = WIN_W'(actSlot) * WIN_W'(SLOT_BITS);
  assign winEnd   = winStart + WIN_W'(actBits);
  assign inWindow = (posWide >= winStart) && (posWide < winEnd);

  assign chanClkEn = strobes.muxMode ? inWindow : 1'b1;
  assign chanRxClk = lineClk;
  assign chanTxClk = strobes.muxMode ? lineClk : txClkPin;

  // Checker state: length of the current run of enabled bits
  logic [POS_W:0] enRun;
  always_ff @(posedge lineClk or negedge rst_n) begin
    if (!rst_n)                              enRun <= '0;
    else if (strobes.syncHit)                enRun <= '0;
    else if (strobes.muxMode && chanClkEn)   enRun <= enRun + 1'b1;
    else                                     enRun <= '0;
  end

  // R4: a frame sync restarts the count at bit 0
  p_count_restart_r4: assert property (@(posedge lineClk) disable iff (!rst_n)
    strobes.syncHit |=> (bitPos == '0));

  // R5: enable only inside the programmed slot
  p_en_in_slot_r5: assert property (@(posedge lineClk) disable iff (!rst_n)
    (strobes.muxMode && chanClkEn) |-> ((32'(bitPos) / SLOT_BITS) == 32'(actSlot)));

  // R6: no run of enabled bits longer than the active bit count
  p_en_span_r6: assert property (@(posedge lineClk) disable iff (!rst_n)
    (strobes.muxMode && chanClkEn) |-> (32'(enRun) < 32'(actBits)));

endmodule

// File: rtl/tsa_clock_gate.sv
module tsa_clock_gate
  import tsa_clock_gate_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                             lineClk,
  input  logic                             rst_n,
  input  logic                             txClkOrSync,
  input  logic                             cfgWrite,
  input  logic                             cfgMuxMode,
  input  logic [$clog2(SLOTS)-1:0]         cfgSlot,
  input  logic [$clog2(SLOT_BITS + 1)-1:0] cfgBits,
  output logic                             chanRxClk,
  output logic                             chanTxClk,
  output logic                             chanClkEn
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS + 1);

  tsaCtrl_t          strobes;
  logic [SLOT_W-1:0] actSlot;
  logic [BIT_W-1:0]  actBits;

  tsa_clock_gate_ctrl #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
    .lineClk    (lineClk),
    .rst_n      (rst_n),
    .syncPin    (txClkOrSync),
    .cfgWrite   (cfgWrite),
    .cfgMuxMode (cfgMuxMode),
    .cfgSlot    (cfgSlot),
    .cfgBits    (cfgBits),
    .strobes    (strobes),
    .actSlot    (actSlot),
    .actBits    (actBits)
  );

  tsa_clock_gate_datapath #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_datapath (
    .lineClk   (lineClk),
    .rst_n     (rst_n),
    .txClkPin  (txClkOrSync),
    .strobes   (strobes),
    .actSlot   (actSlot),
    .actBits   (actBits),
    .chanRxClk (chanRxClk),
    .chanTxClk (chanTxClk),
    .chanClkEn (chanClkEn)
  );

endmodule

// File: tb/tsa_clock_gate_bench.sv
`timescale 1ns/1ps
module tsa_clock_gate_bench;

  localparam int SLOTS     = 32;
  localparam int SLOT_BITS = 8;
  localparam int FRAME_LEN = SLOTS * SLOT_BITS;

  logic       lineClk = 1'b0;
  logic       rst_n;
  logic       txClkOrSync;
  logic       cfgWrite;
  logic       cfgMuxMode;
  logic [4:0] cfgSlot;
  logic [3:0] cfgBits;
  logic       chanRxClk, chanTxClk, chanClkEn;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string phaseTag = "R1";

  always #2.5 lineClk = ~lineClk;

  tsa_clock_gate u_tsa_clock_gate (
    .lineClk(lineClk), .rst_n(rst_n), .txClkOrSync(txClkOrSync),
    .cfgWrite(cfgWrite), .cfgMuxMode(cfgMuxMode), .cfgSlot(cfgSlot),
    .cfgBits(cfgBits), .chanRxClk(chanRxClk), .chanTxClk(chanTxClk),
    .chanClkEn(chanClkEn)
  );

  // Frame model built from the requirements
  logic mPrev, mMux, sMux;
  int   mPos, mSlot, mBits, sSlot, sBits;

  always @(posedge lineClk or negedge rst_n) begin
    if (!rst_n) begin
      mPrev <= 0; mPos <= 0; mMux <= 0; mSlot <= 0; mBits <= SLOT_BITS;
      sMux <= 0; sSlot <= 0; sBits <= SLOT_BITS;
    end else begin
      if (cfgWrite) begin
        sMux  <= cfgMuxMode;
        sSlot <= cfgSlot;
        sBits <= (cfgBits == 0 || cfgBits > SLOT_BITS) ? SLOT_BITS : int'(cfgBits);
      end
      mPrev <= txClkOrSync;
      if (txClkOrSync && !mPrev) begin
        mPos <= 0; mMux <= sMux; mSlot <= sSlot; mBits <= sBits;
      end else begin
        mPos <= (mPos + 1) % FRAME_LEN;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(logic lvl);
    int expEn;
    string clkTag;
    expEn = mMux ? int'(mPos >= mSlot * SLOT_BITS && mPos < mSlot * SLOT_BITS + mBits) : 1;
    clkTag = mMux ? "R3" : "R2";
    chk(phaseTag, "chanClkEn", int'(chanClkEn), expEn);
    chk(clkTag, "chanRxClk", int'(chanRxClk), int'(lvl));
    chk(clkTag, "chanTxClk", int'(chanTxClk), mMux ? int'(lvl) : int'(txClkOrSync));
  endtask

  // Continuous comparison in both clock phases, away from the edges
  always begin
    @(posedge lineClk); #1.25;
    if (!done) compareAll(1'b1);
    @(negedge lineClk); #1.25;
    if (!done) compareAll(1'b0);
  end

  task automatic writeCfg(logic mux, int slot, int bitsVal);
    @(negedge lineClk);
    cfgWrite = 1; cfgMuxMode = mux; cfgSlot = 5'(slot); cfgBits = 4'(bitsVal);
    @(negedge lineClk);
    cfgWrite = 0;
  endtask

  task automatic pulseSync();
    txClkOrSync = 1;
    @(negedge lineClk);
    txClkOrSync = 0;
  endtask

  task automatic runFrame(int slot, int bitsVal, string tag);
    writeCfg(1'b1, slot, bitsVal);
    phaseTag = tag;
    pulseSync();
    repeat (FRAME_LEN) @(negedge lineClk);
  endtask

  initial begin
    rst_n = 0; txClkOrSync = 0; cfgWrite = 0; cfgMuxMode = 0; cfgSlot = 0; cfgBits = 0;
    repeat (3) @(negedge lineClk);
    chk("R1", "chanClkEn in reset", int'(chanClkEn), 1);
    rst_n = 1;
    @(negedge lineClk);
    chk("R1", "chanClkEn after reset", int'(chanClkEn), 1);

    // Pass-through: tx pin used as a clock
    phaseTag = "R2";
    for (int i = 0; i < 40; i++) begin
      @(negedge lineClk);
      txClkOrSync = ~txClkOrSync;
    end
    txClkOrSync = 0;

    // R8: mux written but not yet active, pin held low
    writeCfg(1'b1, 4, 3);
    phaseTag = "R8";
    repeat (20) @(negedge lineClk);
    chk("R8", "enable before sync", int'(chanClkEn), 1);

    // R5 R6: every slot with every legal bit count
    for (int s = 0; s < SLOTS; s++)
      for (int b = 1; b <= SLOT_BITS; b++)
        runFrame(s, b, "R5 R6");

    // R7: out-of-range bit counts
    runFrame(0, 0, "R7");
    runFrame(3, 9, "R7");
    runFrame(31, 15, "R7");
    runFrame(12, 0, "R7");

    // R8 mid-frame write, then R4 wrap without sync
    writeCfg(1'b1, 2, 4);
    phaseTag = "R8";
    pulseSync();
    repeat (100) @(negedge lineClk);
    writeCfg(1'b1, 3, 8);
    phaseTag = "R4";
    repeat (FRAME_LEN + 60) @(negedge lineClk);
    phaseTag = "R8";
    pulseSync();
    repeat (FRAME_LEN) @(negedge lineClk);

    // Back to pass-through at next sync
    writeCfg(1'b0, 0, 8);
    phaseTag = "R2";
    pulseSync();
    repeat (10) @(negedge lineClk);
    @(posedge lineClk); #1.25;
    chk("R2", "enable after return", int'(chanClkEn), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge lineClk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule